// File: doc/BRIEF.md
# Prescaled Capture/Compare Timer with Periodic Interrupt

This block is a timer subsystem. A 16-bit up-counter advances on ticks from a selectable prescaler. Software can read the counter but has no way to write it.

Three input-capture channels record the counter value when a chosen edge appears on their pins. Five output-compare channels raise a flag when the counter reaches their programmed value. On the same match they can set, clear or toggle their output pin.

The same clock divider chain also gives a periodic interrupt at one of four rates. The counter has a wrap flag. Every event source has its own sticky flag and its own enable. The enabled flags are combined into one interrupt line.

All control values are level inputs held by an outside register file. Flags are cleared by pulsing a one on the matching bit of a clear vector. A pulse on the high-byte read strobe freezes the counter's low byte, so a two-byte read returns one consistent value.

Top module: `capcmp_timer`

## Requirements
- R1: After reset `count_o` is 0. It rises by exactly one per prescaler tick, wraps modulo 2^16, and has no write path.
- R2: `psc_sel_i` picks the tick rate: 00 gives every clock, 01 every 4th clock, 10 every 8th and 11 every 16th. Ticks fall on clocks 4, 8, 12… after reset for divide-by-4, and likewise for the others.
- R3: Flag bit 8 sets on the same edge where the counter goes from 0xFFFF to 0x0000.
- R4: Capture channel i uses edge code `cap_edge_i[2i+1:2i]`: 00 off, 01 rising, 10 falling, 11 both.
  - On a selected edge it loads the counter into `cap_val_o[16i+15:16i]` and sets flag bit i.
  - The pin passes a two-flop synchronizer, so the stored value is the count seen two clocks after the pin changes.
- R5: A capture channel whose edge code is 00 keeps its latch and its flag unchanged, whatever its pin does.
- R6: Compare channel j sets flag bit 3+j on the edge where `count_o` becomes equal to `cmp_val_i[16j+15:16j]`.
- R7: On that same edge, pin j follows `cmp_act_i[2j+1:2j]`: 00 no change, 01 toggle, 10 drive low, 11 drive high. Pins reset to 0.
- R8: Flag bit 9 first sets 2^(13+`rti_sel_i`) clocks after reset, then repeats with that period.
- R9: A one on a `flag_clr_i` bit clears that flag. A set and a clear in the same cycle leave the flag set.
- R10: `irq_o` is high exactly when some flag and its matching `irq_en_i` bit are both 1.
- R11: When `cnt_hi_rd_i` is high in a cycle, `cnt_lo_o` captures the counter's low byte from that cycle and holds it until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psc_sel_i | input | 2 | Prescaler select |
| rti_sel_i | input | 2 | Periodic interrupt rate select |
| cap_pin_i | input | 3 | Capture pins |
| cap_edge_i | input | 6 | Capture edge codes, 2 bits per channel |
| cap_val_o | output | 48 | Capture latches, 16 bits per channel |
| cmp_val_i | input | 80 | Compare values, 16 bits per channel |
| cmp_act_i | input | 10 | Compare pin actions, 2 bits per channel |
| cmp_pin_o | output | 5 | Compare output pins |
| irq_en_i | input | 10 | Interrupt enables, same layout as flags |
| flag_clr_i | input | 10 | Write-one-to-clear flag strobes |
| flag_o | output | 10 | Flags: [2:0] capture, [7:3] compare, [8] wrap, [9] periodic |
| irq_o | output | 1 | Combined interrupt |
| count_o | output | 16 | Live counter value |
| cnt_hi_rd_i | input | 1 | High-byte read strobe |
| cnt_lo_o | output | 8 | Frozen low byte |

## Verification
A divider fault shows up as a wrong `count_o` within one prescaler period of reset. The bench detects it by sampling the count after a fixed number of clocks for each divide setting.

A compare-match fault surfaces on the same edge where `count_o` equals the programmed value, as a missing or misplaced flag or pin change. A capture fault surfaces three clocks after the pin moves, as a latch value that differs from the count seen one clock earlier.

Wrap and periodic flags are checked on the exact clock where they must first rise, and on the clock just before it.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } act_e;
endpackage

// File: rtl/capcmp_chain.sv
module capcmp_chain #(
  parameter int CNT_W    = 16,
  parameter int CHAIN_W  = 16,
  parameter int RTI_BASE = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       psc_sel_i,
  input  logic [1:0]       rti_sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tick_o,
  output logic             ovf_hit_o,
  output logic             rti_hit_o
);
  localparam int PSC_W = 4;

  logic [CHAIN_W-1:0] chain_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [PSC_W-1:0]   psc_mask;
  logic [CHAIN_W-1:0] rti_mask;

  always_comb begin
    unique case (psc_sel_i)
      2'd0:    psc_mask = 4'h0;
      2'd1:    psc_mask = 4'h3;
      2'd2:    psc_mask = 4'h7;
      default: psc_mask = 4'hF;
    endcase
  end

  always_comb begin
    for (int i = 0; i < CHAIN_W; i++)
      rti_mask[i] = (i < RTI_BASE + int'(rti_sel_i));
  end

  assign tick_o    = (chain_q[PSC_W-1:0] & psc_mask) == psc_mask;
  assign ovf_hit_o = tick_o && (&cnt_q);
  assign rti_hit_o = &(chain_q | ~rti_mask);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      cnt_q   <= '0;
    end else begin
      chain_q <= chain_q + CHAIN_W'(1);
      if (tick_o) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R1
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  // R1
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(cnt_q));
  // R3
  ovf_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_hit_o |=> cnt_q == '0);
  // R8
  rti_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rti_hit_o |=> (chain_q & $past(rti_mask)) == '0);
endmodule

// File: rtl/capcmp_capture.sv
module capcmp_capture #(
  parameter int CNT_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pin_i,
  input  capcmp_pkg::edge_e   edge_sel_i,
  input  logic [CNT_W-1:0]    cnt_i,
  output logic                hit_o,
  output logic [CNT_W-1:0]    cap_o
);
  import capcmp_pkg::*;

  logic s1_q, s2_q, s3_q;
  logic rise, fall;

  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;

  always_comb begin
    unique case (edge_sel_i)
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_BOTH: hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
      cap_o <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (hit_o) cap_o <= cnt_i;
    end
  end

  // R4
  cap_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> cap_o == $past(cnt_i));
  // R5
  cap_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_sel_i == EDGE_OFF) |=> $stable(cap_o));
endmodule

// File: rtl/capcmp_compare.sv
module capcmp_compare #(
  parameter int CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [CNT_W-1:0]   cmp_i,
  input  capcmp_pkg::act_e   act_i,
  output logic               hit_o,
  output logic               pin_o
);
  import capcmp_pkg::*;

  // match is flagged on the edge where the counter becomes equal
  assign hit_o = tick_i && ((cnt_i + CNT_W'(1)) == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_o <= 1'b0;
    else if (hit_o) begin
      unique case (act_i)
        ACT_TOGGLE: pin_o <= ~pin_o;
        ACT_LOW:    pin_o <= 1'b0;
        ACT_HIGH:   pin_o <= 1'b1;
        default:    pin_o <= pin_o;
      endcase
    end
  end

  // R6
  cmp_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> cnt_i == $past(cmp_i));
  // R7
  cmp_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && act_i == ACT_TOGGLE) |=> pin_o != $past(pin_o));
  // R7
  cmp_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |=> $stable(pin_o));
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer #(
  parameter int CNT_W    = 16,
  parameter int N_CAP    = 3,
  parameter int N_CMP    = 5,
  parameter int RTI_BASE = 13,
  localparam int N_FLAG  = N_CAP + N_CMP + 2,
  localparam int CHAIN_W = RTI_BASE + 3,
  localparam int BYTE_W  = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             psc_sel_i,
  input  logic [1:0]             rti_sel_i,
  input  logic [N_CAP-1:0]       cap_pin_i,
  input  logic [2*N_CAP-1:0]     cap_edge_i,
  output logic [CNT_W*N_CAP-1:0] cap_val_o,
  input  logic [CNT_W*N_CMP-1:0] cmp_val_i,
  input  logic [2*N_CMP-1:0]     cmp_act_i,
  output logic [N_CMP-1:0]       cmp_pin_o,
  input  logic [N_FLAG-1:0]      irq_en_i,
  input  logic [N_FLAG-1:0]      flag_clr_i,
  output logic [N_FLAG-1:0]      flag_o,
  output logic                   irq_o,
  output logic [CNT_W-1:0]       count_o,
  input  logic                   cnt_hi_rd_i,
  output logic [BYTE_W-1:0]      cnt_lo_o
);
  import capcmp_pkg::*;

  localparam int OVF_IDX = N_CAP + N_CMP;
  localparam int RTI_IDX = OVF_IDX + 1;

  logic [CNT_W-1:0]  cnt;
  logic              tick, ovf_hit, rti_hit;
  logic [N_FLAG-1:0] flag_set, flag_q;
  logic [BYTE_W-1:0] lo_snap_q;

  capcmp_chain #(.CNT_W(CNT_W), .CHAIN_W(CHAIN_W), .RTI_BASE(RTI_BASE)) u_chain (
    .clk_i, .rst_ni, .psc_sel_i, .rti_sel_i,
    .cnt_o(cnt), .tick_o(tick), .ovf_hit_o(ovf_hit), .rti_hit_o(rti_hit)
  );

  for (genvar i = 0; i < N_CAP; i++) begin : g_cap
    capcmp_capture #(.CNT_W(CNT_W)) u_cap (
      .clk_i, .rst_ni,
      .pin_i(cap_pin_i[i]),
      .edge_sel_i(edge_e'(cap_edge_i[2*i +: 2])),
      .cnt_i(cnt),
      .hit_o(flag_set[i]),
      .cap_o(cap_val_o[CNT_W*i +: CNT_W])
    );
  end

  for (genvar j = 0; j < N_CMP; j++) begin : g_cmp
    capcmp_compare #(.CNT_W(CNT_W)) u_cmp (
      .clk_i, .rst_ni,
      .tick_i(tick),
      .cnt_i(cnt),
      .cmp_i(cmp_val_i[CNT_W*j +: CNT_W]),
      .act_i(act_e'(cmp_act_i[2*j +: 2])),
      .hit_o(flag_set[N_CAP+j]),
      .pin_o(cmp_pin_o[j])
    );
  end

  assign flag_set[OVF_IDX] = ovf_hit;
  assign flag_set[RTI_IDX] = rti_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q    <= '0;
      lo_snap_q <= '0;
    end else begin
      flag_q <= (flag_q & ~flag_clr_i) | flag_set;  // set wins
      if (cnt_hi_rd_i) lo_snap_q <= cnt[BYTE_W-1:0];
    end
  end

  assign flag_o   = flag_q;
  assign irq_o    = |(flag_q & irq_en_i);
  assign count_o  = cnt;
  assign cnt_lo_o = lo_snap_q;

  // R9
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (flag_q & $past(flag_set)) == $past(flag_set));
  // R9
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (flag_q & $past(flag_clr_i & ~flag_set)) == '0);
  // R11
  snap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_hi_rd_i |=> $stable(lo_snap_q));
endmodule

// File: tb/capcmp_timer_bench.sv
module capcmp_timer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  psc_sel_i = '0, rti_sel_i = '0;
  logic [2:0]  cap_pin_i = '0;
  logic [5:0]  cap_edge_i = '0;
  logic [47:0] cap_val_o;
  logic [79:0] cmp_val_i = '0;
  logic [9:0]  cmp_act_i = '0;
  logic [4:0]  cmp_pin_o;
  logic [9:0]  irq_en_i = '0, flag_clr_i = '0, flag_o;
  logic        irq_o;
  logic [15:0] count_o;
  logic        cnt_hi_rd_i = 1'b0;
  logic [7:0]  cnt_lo_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  capcmp_timer u_capcmp_timer (.*);

  localparam int NV = 8;
  localparam int VEC_PSC [NV] = '{0, 1, 2, 3, 3, 3, 1, 1};
  localparam int VEC_N   [NV] = '{40, 40, 40, 40, 47, 48, 3, 4};
  localparam int VEC_EXP [NV] = '{40, 10, 5, 2, 2, 3, 0, 1};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic cap_drive(input logic [2:0] p, output logic [15:0] exp);
    cap_pin_i = p;
    @(posedge clk_i);
    @(posedge clk_i);
    #1 exp = count_o;
    run(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] e0, e1, snap;

    // reset state: R1, R7, R10
    rst_ni = 1'b0;
    run(2);
    chk(count_o == 0, "R1 reset count", count_o, 0);
    chk(flag_o == 0 && irq_o == 0, "R10 reset flags", flag_o, 0);
    chk(cmp_pin_o == 0, "R7 reset pins", cmp_pin_o, 0);

    // prescaler table: R1, R2
    for (int v = 0; v < NV; v++) begin
      psc_sel_i = 2'(VEC_PSC[v]);
      do_reset();
      run(VEC_N[v]);
      chk(count_o == 16'(VEC_EXP[v]), "R2 prescaler count", count_o, VEC_EXP[v]);
    end

    // compare: R6, R7, R9, R10
    psc_sel_i = 2'd0;
    cmp_val_i[15:0]  = 16'd20; cmp_act_i[1:0] = 2'b01;
    cmp_val_i[31:16] = 16'd20; cmp_act_i[3:2] = 2'b11;
    cmp_val_i[47:32] = 16'd10; cmp_act_i[5:4] = 2'b11;
    cmp_val_i[63:48] = 16'd20; cmp_act_i[7:6] = 2'b00;
    irq_en_i = 10'b00_0000_1000;
    do_reset();
    run(19);
    chk(cmp_pin_o[0] == 0 && flag_o[3] == 0, "R6 before match", {cmp_pin_o[0], flag_o[3]}, 0);
    chk(irq_o == 0, "R10 irq idle", irq_o, 0);
    run(1);
    chk(flag_o[7:3] == 5'b01111, "R6 match flags", flag_o[7:3], 5'b01111);
    chk(cmp_pin_o[3:0] == 4'b0111, "R7 pin actions", cmp_pin_o[3:0], 4'b0111);
    chk(irq_o == 1, "R10 irq raised", irq_o, 1);
    cmp_val_i[47:32] = 16'd30; cmp_act_i[5:4] = 2'b10;
    run(10);
    chk(cmp_pin_o[2] == 0, "R7 drive low", cmp_pin_o[2], 0);
    flag_clr_i = 10'b00_0000_1000;
    run(1);
    flag_clr_i = '0;
    chk(flag_o[3] == 0 && flag_o[4] == 1, "R9 w1c", flag_o[4:3], 2'b10);
    chk(irq_o == 0, "R10 irq cleared", irq_o, 0);

    // capture: R4, R5
    cap_edge_i = 6'b00_10_01;
    irq_en_i = '0;
    do_reset();
    run(5);
    cap_drive(3'b111, e0);
    chk(cap_val_o[15:0] == e0 && flag_o[0], "R4 rising capture", cap_val_o[15:0], e0);
    chk(flag_o[2:1] == 0 && cap_val_o[47:32] == 0, "R5 disabled channel", flag_o[2:1], 0);
    run(3);
    cap_drive(3'b000, e1);
    chk(cap_val_o[31:16] == e1 && flag_o[1], "R4 falling capture", cap_val_o[31:16], e1);
    chk(cap_val_o[15:0] == e0, "R4 rising ignores fall", cap_val_o[15:0], e0);
    chk(flag_o[2] == 0 && cap_val_o[47:32] == 0, "R5 disabled after fall", cap_val_o[47:32], 0);
    cap_edge_i[5:4] = 2'b11;
    run(2);
    cap_drive(3'b100, e1);
    chk(cap_val_o[47:32] == e1 && flag_o[2], "R4 both-edge capture", cap_val_o[47:32], e1);

    // snapshot: R11
    cnt_hi_rd_i = 1'b1;
    snap = count_o;
    run(1);
    cnt_hi_rd_i = 1'b0;
    run(5);
    chk(cnt_lo_o == snap[7:0], "R11 low byte frozen", cnt_lo_o, snap[7:0]);

    // periodic: R8
    rti_sel_i = 2'd0;
    do_reset();
    run(8191);
    chk(flag_o[9] == 0, "R8 rate0 early", flag_o[9], 0);
    run(1);
    chk(flag_o[9] == 1, "R8 rate0 hit", flag_o[9], 1);
    rti_sel_i = 2'd1;
    do_reset();
    run(16383);
    chk(flag_o[9] == 0, "R8 rate1 early", flag_o[9], 0);
    run(1);
    chk(flag_o[9] == 1, "R8 rate1 hit", flag_o[9], 1);

    // wrap: R3
    cmp_val_i = '0;
    do_reset();
    run(65535);
    chk(count_o == 16'hFFFF && flag_o[8] == 0, "R3 before wrap", count_o, 16'hFFFF);
    run(1);
    chk(count_o == 0 && flag_o[8] == 1, "R3 wrap flag", {flag_o[8], count_o}, 17'h10000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule